// File: doc/BRIEF.md
# Flash Controller Interrupt Flag Register

This block holds the sticky event flags of a non-volatile memory controller and turns them into one level-sensitive interrupt request. The controller's state machine pulses an input when an operation completes and pulses other inputs when it detects an error. Each pulse latches the matching flag. Software reads the flag word over a simple register bus. It acknowledges events by writing ones to the bits it has handled.

Software cannot modify the flags while the controller reports busy. The reset or brown-out error input counts only during a program or erase operation. A separate enable mask with the same bit layout selects which flags drive the interrupt. The interrupt output is registered, so it drops one cycle after the last enabled flag clears.

Top module: `nvm_irq_flags`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `bus_rdata` reads zero and `irq` is 0.
- R2: Flag positions in `bus_rdata`: bit 0 operation done, bit 1 unlock-sequence error, bit 2 configuration error, bit 3 write-buffer underrun, bit 4 bus fault during row write, bit 5 protected-region error, bit 6 disabled-operation error, bit 7 security error, bit 12 reset/brown-out error, bit 13 program/erase failure. Every other bit always reads 0, so the full word is 0x000030FF when all flags are set.
- R3: An event input that is high at a rising clock edge sets its flag, and `bus_rdata` shows the flag after that edge.
- R4: A bus write with `busy` low clears each flag whose `bus_wdata` bit is 1. Flags whose `bus_wdata` bit is 0 keep their value.
- R5: A bus write never sets a flag, whatever `bus_wdata` holds.
- R6: A bus write while `busy` is high changes no flag.
- R7: If an event and a clearing write hit the same flag at the same edge, the flag ends up set.
- R8: `ev_rst_brown` sets bit 12 only when `op_active` is high at the same edge. Otherwise it is ignored.
- R9: `irq` at each edge takes the OR of (`bus_rdata` AND `irq_en`) from the cycle before. It stays high as long as that product is nonzero.
- R10: Reading `bus_rdata` has no side effects. The flag word holds steady across idle cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_en | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Write data; a 1 requests a clear of that flag |
| bus_rdata | output | 32 | Current flag word |
| busy | input | 1 | Controller busy status; blocks software clears |
| op_active | input | 1 | A program or erase operation is in progress |
| ev_done | input | 1 | Operation-finished pulse |
| ev_key_err | input | 1 | Unlock-sequence error pulse |
| ev_cfg_err | input | 1 | Configuration error pulse |
| ev_fifo_err | input | 1 | Write-buffer underrun pulse |
| ev_bus_err | input | 1 | Bus fault during row write pulse |
| ev_wp_err | input | 1 | Protected-region error pulse |
| ev_op_err | input | 1 | Disabled-operation error pulse |
| ev_sec_err | input | 1 | Security error pulse |
| ev_rst_brown | input | 1 | Reset or low-voltage detect |
| ev_wr_err | input | 1 | Program/erase failure pulse |
| irq_en | input | 32 | Interrupt enable mask, same layout as the flags |
| irq | output | 1 | Level interrupt request |

## Verification
A hardware event and a software clear can land on the same flag at the same edge. In that case the event must win. The bench provokes this on purpose: it writes an all-ones clear in the same cycle it pulses one error input, then checks that only that flag survives. It also raises many random collisions of events, writes and busy, and compares every cycle against a behavioural model. In that model, the set is applied after the clear.

// File: rtl/nvm_irq_pkg.sv
package nvm_irq_pkg;
   localparam int unsigned NUM_FLAGS = 10;
   localparam int unsigned MIN_WORD  = 14;

   typedef enum int unsigned {
      FL_DONE = 0, FL_KEY = 1, FL_CFG = 2, FL_FIFO = 3, FL_BUS = 4,
      FL_WP = 5, FL_OP = 6, FL_SEC = 7, FL_RSTBO = 8, FL_WRFAIL = 9
   } flag_idx_e;

   // bit position in the register word for each flag index
   function automatic int unsigned flag_pos(input int unsigned idx);
      return (idx < 8) ? idx : idx + 4;
   endfunction

   localparam logic [31:0] FLAG_MASK = 32'h0000_30FF;
endpackage

// File: rtl/nvm_irq_flag_cell.sv
module nvm_irq_flag_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   // set has priority so no hardware event is lost
   always_ff @(posedge clk) begin
      if (!rst_n)      q_o <= 1'b0;
      else if (set_i)  q_o <= 1'b1;
      else if (clr_i)  q_o <= 1'b0;
   end
endmodule

// File: rtl/nvm_irq_gen.sv
module nvm_irq_gen #(
   parameter int unsigned WIDTH      = 32,
   parameter bit          REGISTERED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] flags_i,
   input  logic [WIDTH-1:0] en_i,
   output logic             irq_o
);
   logic req;
   assign req = |(flags_i & en_i);

   generate
      if (REGISTERED) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) irq_o <= 1'b0;
            else        irq_o <= req;
         end
      end else begin : g_comb
         logic clk_rst_unused;
         assign clk_rst_unused = clk ^ rst_n;
         assign irq_o = req;
      end
   endgenerate
endmodule

// File: rtl/nvm_irq_flags.sv
module nvm_irq_flags
   import nvm_irq_pkg::*;
#(
   parameter int unsigned DATA_W       = 32,
   parameter bit          IRQ_REGISTER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr_en,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              busy,
   input  logic              op_active,
   input  logic              ev_done,
   input  logic              ev_key_err,
   input  logic              ev_cfg_err,
   input  logic              ev_fifo_err,
   input  logic              ev_bus_err,
   input  logic              ev_wp_err,
   input  logic              ev_op_err,
   input  logic              ev_sec_err,
   input  logic              ev_rst_brown,
   input  logic              ev_wr_err,
   input  logic [DATA_W-1:0] irq_en,
   output logic              irq
);
   localparam logic [DATA_W-1:0] WMASK = DATA_W'(FLAG_MASK);

   generate
      if (DATA_W < MIN_WORD) begin : g_bad_width
         $error("nvm_irq_flags: DATA_W must be at least %0d", MIN_WORD);
      end
   endgenerate

   logic [NUM_FLAGS-1:0] hw_set;
   logic [NUM_FLAGS-1:0] sw_clr;
   logic [NUM_FLAGS-1:0] flag_q;
   logic                 clr_ok;
   logic [DATA_W-1:0]    word;
   logic                 wdata_spare_unused;

   assign hw_set[FL_DONE]   = ev_done;
   assign hw_set[FL_KEY]    = ev_key_err;
   assign hw_set[FL_CFG]    = ev_cfg_err;
   assign hw_set[FL_FIFO]   = ev_fifo_err;
   assign hw_set[FL_BUS]    = ev_bus_err;
   assign hw_set[FL_WP]     = ev_wp_err;
   assign hw_set[FL_OP]     = ev_op_err;
   assign hw_set[FL_SEC]    = ev_sec_err;
   assign hw_set[FL_RSTBO]  = ev_rst_brown & op_active;
   assign hw_set[FL_WRFAIL] = ev_wr_err;

   assign clr_ok             = bus_wr_en & ~busy;
   assign wdata_spare_unused = ^(bus_wdata & ~WMASK);

   always_comb begin
      word = '0;
      for (int unsigned i = 0; i < NUM_FLAGS; i++) begin
         word[flag_pos(i)] = flag_q[i];
      end
   end

   genvar gi;
   generate
      for (gi = 0; gi < NUM_FLAGS; gi++) begin : g_flag
         assign sw_clr[gi] = clr_ok & bus_wdata[flag_pos(gi)];
         nvm_irq_flag_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (hw_set[gi]),
            .clr_i (sw_clr[gi]),
            .q_o   (flag_q[gi])
         );
      end
   endgenerate

   assign bus_rdata = word;

   nvm_irq_gen #(
      .WIDTH      (DATA_W),
      .REGISTERED (IRQ_REGISTER)
   ) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .flags_i (word),
      .en_i    (irq_en),
      .irq_o   (irq)
   );
endmodule

// File: rtl/nvm_irq_flags_chk.sv
module nvm_irq_flags_chk
   import nvm_irq_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr_en,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              busy,
   input logic              op_active,
   input logic              ev_done,
   input logic              ev_key_err,
   input logic              ev_cfg_err,
   input logic              ev_fifo_err,
   input logic              ev_bus_err,
   input logic              ev_wp_err,
   input logic              ev_op_err,
   input logic              ev_sec_err,
   input logic              ev_rst_brown,
   input logic              ev_wr_err,
   input logic [DATA_W-1:0] irq_en,
   input logic              irq
);
   localparam logic [DATA_W-1:0] WMASK = DATA_W'(FLAG_MASK);
   logic [DATA_W-1:0] evw;

   always_comb begin
      evw = '0;
      evw[0]  = ev_done;
      evw[1]  = ev_key_err;
      evw[2]  = ev_cfg_err;
      evw[3]  = ev_fifo_err;
      evw[4]  = ev_bus_err;
      evw[5]  = ev_wp_err;
      evw[6]  = ev_op_err;
      evw[7]  = ev_sec_err;
      evw[12] = ev_rst_brown & op_active;
      evw[13] = ev_wr_err;
   end

   p_unimpl_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rdata & ~WMASK) == '0);

   p_event_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (|evw) |=> ((bus_rdata & $past(evw)) == $past(evw)));

   p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_en && !busy) |=> ((bus_rdata & $past(bus_wdata & ~evw & WMASK)) == '0));

   p_no_sw_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((bus_rdata & ~$past(bus_rdata) & ~$past(evw)) == '0));

   p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (($past(bus_rdata) & ~bus_rdata) == '0));

   p_rstbo_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_rdata[12] && !(ev_rst_brown && op_active)) |=> !bus_rdata[12]);

   p_irq_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq == $past(|(bus_rdata & irq_en))));
endmodule

bind nvm_irq_flags nvm_irq_flags_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/nvm_irq_flags_tb.sv
`timescale 1ns/1ps
module nvm_irq_flags_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        busy = 1'b0;
   logic        op_act = 1'b0;
   logic [9:0]  ev = '0;
   logic [31:0] en = '0;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   // reference state
   logic [31:0] m_flags = '0;
   logic        m_irq = 1'b0;

   always #2.5 clk = ~clk;

   nvm_irq_flags u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr_en(wr_en), .bus_wdata(wdata),
      .bus_rdata(rdata), .busy(busy), .op_active(op_act),
      .ev_done(ev[0]), .ev_key_err(ev[1]), .ev_cfg_err(ev[2]),
      .ev_fifo_err(ev[3]), .ev_bus_err(ev[4]), .ev_wp_err(ev[5]),
      .ev_op_err(ev[6]), .ev_sec_err(ev[7]), .ev_rst_brown(ev[8]),
      .ev_wr_err(ev[9]), .irq_en(en), .irq(irq)
   );

   function automatic int bitpos(input int i);
      return (i < 8) ? i : i + 4;
   endfunction

   always @(posedge clk) begin
      logic [31:0] setw, clrw;
      setw = '0;
      for (int i = 0; i < 10; i++)
         if (ev[i] && (i != 8 || op_act)) setw[bitpos(i)] = 1'b1;
      clrw = (wr_en && !busy) ? wdata : '0;
      if (!rst_n) begin
         m_flags <= '0;
         m_irq   <= 1'b0;
      end else begin
         m_flags <= ((m_flags & ~clrw) | setw) & 32'h0000_30FF;
         m_irq   <= |(m_flags & en);
      end
   end

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      check(rdata === m_flags, "R3 flag word vs model", rdata, m_flags);
      check(irq === m_irq, "R9 irq vs model", {31'd0, irq}, {31'd0, m_irq});
      ev    = '0;
      wr_en = 1'b0;
   endtask

   task automatic sw_write(input logic [31:0] d);
      wr_en = 1'b1;
      wdata = d;
      tick();
   endtask

   initial begin
      #(5.0 * 20000);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] snap;
      @(negedge clk);
      tick();
      tick();
      // R1: reset state
      check(rdata === 32'd0, "R1 rdata in reset", rdata, 32'd0);
      check(irq === 1'b0, "R1 irq in reset", {31'd0, irq}, 32'd0);
      rst_n = 1'b1;
      tick();
      check(rdata === 32'd0, "R1 rdata after reset", rdata, 32'd0);

      // R5: writing ones cannot set flags
      sw_write(32'hFFFF_FFFF);
      check(rdata === 32'd0, "R5 write ones sets nothing", rdata, 32'd0);

      // R3 and R2: each event lands at its position
      op_act = 1'b1;
      for (int i = 0; i < 10; i++) begin
         ev[i] = 1'b1;
         tick();
         check(rdata[bitpos(i)] === 1'b1, "R3 event sets its bit", rdata,
               32'd1 << bitpos(i));
      end
      op_act = 1'b0;
      check(rdata === 32'h0000_30FF, "R2 full layout", rdata, 32'h0000_30FF);

      // R10: idle reads leave state alone
      snap = rdata;
      tick();
      tick();
      check(rdata === snap, "R10 read has no side effect", rdata, snap);

      // R4: zeros keep, ones clear
      sw_write(32'h0000_0000);
      check(rdata === 32'h0000_30FF, "R4 write zero keeps", rdata, 32'h0000_30FF);
      sw_write(32'h0000_2001);
      check(rdata === 32'h0000_10FE, "R4 selective clear", rdata, 32'h0000_10FE);

      // R6: clears blocked while busy
      busy = 1'b1;
      sw_write(32'hFFFF_FFFF);
      check(rdata === 32'h0000_10FE, "R6 clear ignored when busy", rdata,
            32'h0000_10FE);
      busy = 1'b0;

      // R7: set wins against same-edge clear
      ev[1] = 1'b1;
      sw_write(32'hFFFF_FFFF);
      check(rdata === 32'h0000_0002, "R7 set beats clear", rdata, 32'h0000_0002);

      // R8: reset/brown-out gated by operation
      ev[8] = 1'b1;
      tick();
      check(rdata[12] === 1'b0, "R8 ignored outside op", rdata, 32'h0000_0002);
      op_act = 1'b1;
      ev[8] = 1'b1;
      tick();
      op_act = 1'b0;
      check(rdata[12] === 1'b1, "R8 captured during op", rdata, 32'h0000_1002);

      // R9: level irq, registered drop
      en = 32'h0000_0002;
      tick();
      check(irq === 1'b1, "R9 irq asserted", {31'd0, irq}, 32'd1);
      tick();
      check(irq === 1'b1, "R9 irq held as level", {31'd0, irq}, 32'd1);
      sw_write(32'h0000_0002);
      check(irq === 1'b1, "R9 irq one cycle late", {31'd0, irq}, 32'd1);
      tick();
      check(irq === 1'b0, "R9 irq drops", {31'd0, irq}, 32'd0);
      en = 32'h0000_1000;
      tick();
      tick();
      check(irq === 1'b1, "R9 irq from bit 12", {31'd0, irq}, 32'd1);

      // random mix, compared with the model every cycle
      for (int n = 0; n < 600; n++) begin
         ev     = 10'($urandom) & 10'($urandom);
         busy   = ($urandom % 4) == 0;
         op_act = $urandom % 2;
         wr_en  = ($urandom % 3) == 0;
         wdata  = $urandom;
         en     = $urandom;
         @(posedge clk);
         @(negedge clk);
         check(rdata === m_flags, "R7 random flag word", rdata, m_flags);
         check(irq === m_irq, "R9 random irq", {31'd0, irq}, {31'd0, m_irq});
      end
      ev = '0;
      wr_en = 1'b0;

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule